// File: doc/BRIEF.md
# Scan Test Sequencer with Chain Flush

This controller drives a full-scan test of a design whose state flip-flops form one or more equal-length serial shift chains. It gates the test clock of the scanned design, drives a single shared test-control line, one serial input per chain and the design's primary inputs, and checks the serial outputs and primary outputs against expected values. A run begins with a chain-integrity flush. Each test vector is then shifted in, one capture clock is applied in normal mode, and the captured response is shifted out while the following vector shifts in. One extra unload follows the last vector.

Vectors reach the block over a valid/ready stream. Each stream item carries the chain load bits, the primary-input values, the expected primary outputs and the expected captured chain state together with a per-bit care mask. Chains shorter than the longest one are padded in the load data, and their padding positions are masked off in the care mask. The block reports a sticky failure flag, the index of the first failing vector, a done pulse and a count of applied test clocks.

Top module: `scan_test_seq`

## Requirements
- R1: `test_ctl_o` is 0 on every shift clock and 1 on exactly one clock per vector (the capture). `pi_o` carries the vector's primary-input bits on that clock and is 0 on all other cycles.
- R2: After `start_i` is taken in idle, the first CHAIN_LEN+4 test clocks shift the pattern 0,0,1,1,0,0,1,1,... into every chain, with test clock t carrying bit 1 of t.
- R3: During the flush, from test clock CHAIN_LEN onward, every `scan_out_i` bit is compared with the flush bit sent CHAIN_LEN clocks earlier. A mismatch sets the failure flag with vector index all ones.
- R4: A vector loads in CHAIN_LEN shift clocks per chain. Chain c occupies bits [c*CHAIN_LEN +: CHAIN_LEN], bit j is the value that flip-flop j (j=0 next to the serial input) holds after the load, and bit CHAIN_LEN-1 is shifted first.
- R5: While vector k+1 loads, and during the final unload after the last vector, shift clock i compares `scan_out_i[c]` with bit CHAIN_LEN-1-i of vector k's expected chain state. Bits whose care-mask bit is 0 are ignored.
- R6: No scan-out comparison takes place during the first load of a run, whatever the values left from an earlier run.
- R7: On the capture clock, `po_i` is compared with the vector's expected primary outputs. A mismatch fails that vector's own index.
- R8: After the last vector's capture, exactly CHAIN_LEN unload clocks follow. Then `done_o` is high for one cycle with `busy_o` low.
- R9: `cycle_cnt_o` counts test clocks from the start and equals (N+2)*CHAIN_LEN+N+4 at `done_o` for N vectors. No test clock is applied, and the count does not move, while the block waits for a vector.
- R10: `fail_o` is sticky, and `fail_vec_o` keeps the index of the first failing vector. Both clear when a new run starts.
- R11: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| vec_valid_i | input | 1 | Stream item present |
| vec_ready_o | output | 1 | Block waiting for the next item |
| vec_last_i | input | 1 | Item is the final vector of the run |
| vec_load_i | input | NCH*CHAIN_LEN | Chain load bits |
| vec_pi_i | input | NPI | Primary-input bits for capture |
| vec_po_exp_i | input | NPO | Expected primary outputs at capture |
| vec_so_exp_i | input | NCH*CHAIN_LEN | Expected captured chain state |
| vec_so_care_i | input | NCH*CHAIN_LEN | Care mask for the captured state |
| tclk_en_o | output | 1 | Test clock of the scanned design is enabled this cycle |
| test_ctl_o | output | 1 | 0 = shift, 1 = capture |
| scan_in_o | output | NCH | Serial data to each chain |
| pi_o | output | NPI | Primary inputs of the scanned design |
| scan_out_i | input | NCH | Serial data from each chain |
| po_i | input | NPO | Primary outputs of the scanned design |
| cycle_cnt_o | output | CYC_W | Applied test clocks since start |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky failure flag |
| fail_vec_o | output | VIDX_W | First failing vector (all ones = flush) |

## Verification
The properties assume that the stream source holds `vec_valid_i` and the item steady until acceptance. They also assume the scanned design shifts or captures only on cycles where `tclk_en_o` is high, and that `start_i` is a level the sequencer may see during a run. The bench presents each item once the block is waiting and drops valid right after the accepting edge. It models the chains as clocked only by `tclk_en_o`, and it raises `start_i` during a run only to show that the pulse is ignored. Expected captured states come from a small next-state function in the bench, so every fault injected into an expected value or into a chain output is a deliberate one.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FLUSH,
    SQ_WAIT,
    SQ_LOAD,
    SQ_CAPT,
    SQ_UNLOAD
  } sq_state_e;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 4,
  parameter int VIDX_W    = 4,
  parameter int CYC_W     = 16,
  localparam int CNT_W    = $clog2(CHAIN_LEN + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              vec_valid_i,
  input  logic              vec_last_i,
  output sq_state_e         state_o,
  output logic [CNT_W-1:0]  step_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [VIDX_W-1:0] cur_idx_o,
  output logic [VIDX_W-1:0] prev_idx_o,
  output logic              have_prev_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(CHAIN_LEN + 3);
  localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(CHAIN_LEN - 1);

  sq_state_e         state_q, state_d;
  logic [CNT_W-1:0]  step_q, step_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [VIDX_W-1:0] idx_q, idx_d, pidx_q, pidx_d;
  logic              prev_q, prev_d, last_q, last_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    cyc_d   = cyc_q;
    idx_d   = idx_q;
    pidx_d  = pidx_q;
    prev_d  = prev_q;
    last_d  = last_q;
    done_d  = 1'b0;
    if (state_q inside {SQ_FLUSH, SQ_LOAD, SQ_CAPT, SQ_UNLOAD}) cyc_d = cyc_q + 1'b1;
    case (state_q)
      SQ_IDLE: if (start_i) begin
        state_d = SQ_FLUSH;
        step_d  = '0;
        cyc_d   = '0;
        idx_d   = '0;
        prev_d  = 1'b0;
      end
      SQ_FLUSH: if (step_q == FLUSH_LAST) begin
        state_d = SQ_WAIT;
        step_d  = '0;
      end else step_d = step_q + 1'b1;
      SQ_WAIT: if (vec_valid_i) begin
        state_d = SQ_LOAD;
        last_d  = vec_last_i;
      end
      SQ_LOAD: if (step_q == SHIFT_LAST) begin
        state_d = SQ_CAPT;
        step_d  = '0;
      end else step_d = step_q + 1'b1;
      SQ_CAPT: begin
        prev_d  = 1'b1;
        pidx_d  = idx_q;
        idx_d   = idx_q + 1'b1;
        state_d = last_q ? SQ_UNLOAD : SQ_WAIT;
      end
      SQ_UNLOAD: if (step_q == SHIFT_LAST) begin
        state_d = SQ_IDLE;
        step_d  = '0;
        done_d  = 1'b1;
      end else step_d = step_q + 1'b1;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      cyc_q   <= '0;
      idx_q   <= '0;
      pidx_q  <= '0;
      prev_q  <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cyc_q   <= cyc_d;
      idx_q   <= idx_d;
      pidx_q  <= pidx_d;
      prev_q  <= prev_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  assign state_o     = state_q;
  assign step_o      = step_q;
  assign cyc_o       = cyc_q;
  assign cur_idx_o   = idx_q;
  assign prev_idx_o  = pidx_q;
  assign have_prev_o = prev_q;
  assign done_o      = done_q;
endmodule

// File: rtl/seq_vec_store.sv
module seq_vec_store #(
  parameter int NCH       = 2,
  parameter int CHAIN_LEN = 4,
  parameter int NPI       = 3,
  parameter int NPO       = 2,
  localparam int CNT_W    = $clog2(CHAIN_LEN + 4),
  localparam int VBITS    = NCH * CHAIN_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic [VBITS-1:0] vec_load_i,
  input  logic [NPI-1:0]   vec_pi_i,
  input  logic [NPO-1:0]   vec_po_exp_i,
  input  logic [VBITS-1:0] vec_so_exp_i,
  input  logic [VBITS-1:0] vec_so_care_i,
  output logic [NCH-1:0]   load_bit_o,
  output logic [NCH-1:0]   so_exp_o,
  output logic [NCH-1:0]   so_care_o,
  output logic [NPI-1:0]   pi_o,
  output logic [NPO-1:0]   po_exp_o
);
  logic [VBITS-1:0] load_q, exp_q, care_q, pexp_q, pcare_q;
  logic [NPI-1:0]   pi_q;
  logic [NPO-1:0]   po_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      exp_q  <= '0;
      care_q <= '0;
      pi_q   <= '0;
      po_q   <= '0;
    end else if (accept_i) begin
      load_q <= vec_load_i;
      exp_q  <= vec_so_exp_i;
      care_q <= vec_so_care_i;
      pi_q   <= vec_pi_i;
      po_q   <= vec_po_exp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pexp_q  <= '0;
      pcare_q <= '0;
    end else if (capture_i) begin
      pexp_q  <= exp_q;
      pcare_q <= care_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ser
    logic [CHAIN_LEN-1:0] ld_sh, ex_sh, ca_sh;
    assign ld_sh = load_q[c*CHAIN_LEN +: CHAIN_LEN] << step_i;
    assign ex_sh = pexp_q[c*CHAIN_LEN +: CHAIN_LEN] << step_i;
    assign ca_sh = pcare_q[c*CHAIN_LEN +: CHAIN_LEN] << step_i;
    assign load_bit_o[c] = ld_sh[CHAIN_LEN-1];
    assign so_exp_o[c]   = ex_sh[CHAIN_LEN-1];
    assign so_care_o[c]  = ca_sh[CHAIN_LEN-1];
  end

  assign pi_o     = pi_q;
  assign po_exp_o = po_q;
endmodule

// File: rtl/seq_compare.sv
module seq_compare #(
  parameter int NCH    = 2,
  parameter int NPO    = 2,
  parameter int VIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              flush_chk_i,
  input  logic              flush_exp_i,
  input  logic              so_chk_i,
  input  logic [NCH-1:0]    so_exp_i,
  input  logic [NCH-1:0]    so_care_i,
  input  logic [NCH-1:0]    scan_out_i,
  input  logic              po_chk_i,
  input  logic [NPO-1:0]    po_exp_i,
  input  logic [NPO-1:0]    po_i,
  input  logic [VIDX_W-1:0] prev_idx_i,
  input  logic [VIDX_W-1:0] cur_idx_i,
  output logic              fail_o,
  output logic [VIDX_W-1:0] fail_vec_o
);
  logic              flush_mis, so_mis, po_mis;
  logic              fail_q, fail_d;
  logic [VIDX_W-1:0] vec_q, vec_d;

  assign flush_mis = flush_chk_i && (scan_out_i != {NCH{flush_exp_i}});
  assign so_mis    = so_chk_i && (|((scan_out_i ^ so_exp_i) & so_care_i));
  assign po_mis    = po_chk_i && (po_i != po_exp_i);

  always_comb begin
    fail_d = fail_q;
    vec_d  = vec_q;
    if (clear_i) begin
      fail_d = 1'b0;
      vec_d  = '0;
    end else if (!fail_q && (flush_mis || so_mis || po_mis)) begin
      fail_d = 1'b1;
      if (flush_mis)   vec_d = '1;
      else if (so_mis) vec_d = prev_idx_i;
      else             vec_d = cur_idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      fail_q <= fail_d;
      vec_q  <= vec_d;
    end
  end

  assign fail_o     = fail_q;
  assign fail_vec_o = vec_q;
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int CHAIN_LEN = 4,
  parameter int NPI       = 3,
  parameter int NPO       = 2,
  parameter int VIDX_W    = 4,
  parameter int CYC_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     vec_valid_i,
  output logic                     vec_ready_o,
  input  logic                     vec_last_i,
  input  logic [NCH*CHAIN_LEN-1:0] vec_load_i,
  input  logic [NPI-1:0]           vec_pi_i,
  input  logic [NPO-1:0]           vec_po_exp_i,
  input  logic [NCH*CHAIN_LEN-1:0] vec_so_exp_i,
  input  logic [NCH*CHAIN_LEN-1:0] vec_so_care_i,
  output logic                     tclk_en_o,
  output logic                     test_ctl_o,
  output logic [NCH-1:0]           scan_in_o,
  output logic [NPI-1:0]           pi_o,
  input  logic [NCH-1:0]           scan_out_i,
  input  logic [NPO-1:0]           po_i,
  output logic [CYC_W-1:0]         cycle_cnt_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [VIDX_W-1:0]        fail_vec_o
);
  localparam int CNT_W = $clog2(CHAIN_LEN + 4);

  sq_state_e         state;
  logic [CNT_W-1:0]  step;
  logic [VIDX_W-1:0] cur_idx, prev_idx;
  logic              have_prev, accept, capture, flush_chk, flush_exp, so_chk;
  logic [NCH-1:0]    load_bit, so_exp, so_care;
  logic [NPI-1:0]    pi_q;
  logic [NPO-1:0]    po_exp;

  seq_ctrl #(.CHAIN_LEN(CHAIN_LEN), .VIDX_W(VIDX_W), .CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_valid_i(vec_valid_i),
    .vec_last_i(vec_last_i), .state_o(state), .step_o(step), .cyc_o(cycle_cnt_o),
    .cur_idx_o(cur_idx), .prev_idx_o(prev_idx), .have_prev_o(have_prev), .done_o(done_o)
  );

  assign accept  = (state == SQ_WAIT) && vec_valid_i;
  assign capture = (state == SQ_CAPT);

  seq_vec_store #(.NCH(NCH), .CHAIN_LEN(CHAIN_LEN), .NPI(NPI), .NPO(NPO)) u_store (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .capture_i(capture), .step_i(step),
    .vec_load_i(vec_load_i), .vec_pi_i(vec_pi_i), .vec_po_exp_i(vec_po_exp_i),
    .vec_so_exp_i(vec_so_exp_i), .vec_so_care_i(vec_so_care_i),
    .load_bit_o(load_bit), .so_exp_o(so_exp), .so_care_o(so_care),
    .pi_o(pi_q), .po_exp_o(po_exp)
  );

  assign flush_chk = (state == SQ_FLUSH) && (step >= CNT_W'(CHAIN_LEN));
  assign flush_exp = 1'((step - CNT_W'(CHAIN_LEN)) >> 1);
  assign so_chk    = ((state == SQ_LOAD) && have_prev) || (state == SQ_UNLOAD);

  seq_compare #(.NCH(NCH), .NPO(NPO), .VIDX_W(VIDX_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear_i((state == SQ_IDLE) && start_i),
    .flush_chk_i(flush_chk), .flush_exp_i(flush_exp), .so_chk_i(so_chk),
    .so_exp_i(so_exp), .so_care_i(so_care), .scan_out_i(scan_out_i),
    .po_chk_i(capture), .po_exp_i(po_exp), .po_i(po_i),
    .prev_idx_i(prev_idx), .cur_idx_i(cur_idx),
    .fail_o(fail_o), .fail_vec_o(fail_vec_o)
  );

  always_comb begin
    case (state)
      SQ_FLUSH: scan_in_o = {NCH{step[1]}};
      SQ_LOAD:  scan_in_o = load_bit;
      default:  scan_in_o = '0;
    endcase
  end

  assign tclk_en_o   = state inside {SQ_FLUSH, SQ_LOAD, SQ_CAPT, SQ_UNLOAD};
  assign test_ctl_o  = capture;
  assign pi_o        = capture ? pi_q : '0;
  assign vec_ready_o = (state == SQ_WAIT);
  assign busy_o      = (state != SQ_IDLE);
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int NPI    = 3,
  parameter int VIDX_W = 4,
  parameter int CYC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              vec_valid_i,
  input logic              vec_ready_o,
  input logic              tclk_en_o,
  input logic              test_ctl_o,
  input logic [NPI-1:0]    pi_o,
  input logic [CYC_W-1:0]  cycle_cnt_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [VIDX_W-1:0] fail_vec_o
);
  logic new_run;
  assign new_run = start_i && !busy_o;

  assert_capture_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    test_ctl_o |=> !test_ctl_o);
  assert_capture_clocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    test_ctl_o |-> tclk_en_o);
  assert_pi_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !test_ctl_o |-> (pi_o == '0));
  assert_load_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_i && vec_ready_o) |=> (tclk_en_o && !test_ctl_o && !vec_ready_o));
  assert_no_clock_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready_o |-> !tclk_en_o);
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tclk_en_o) |=> (cycle_cnt_o == $past(cycle_cnt_o) + 1'b1));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tclk_en_o && !new_run) |=> $stable(cycle_cnt_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !new_run) |=> (fail_o && $stable(fail_vec_o)));
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && tclk_en_o) |=> (cycle_cnt_o != '0));
endmodule

bind scan_test_seq scan_seq_chk #(.NPI(NPI), .VIDX_W(VIDX_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_valid_i(vec_valid_i),
  .vec_ready_o(vec_ready_o), .tclk_en_o(tclk_en_o), .test_ctl_o(test_ctl_o),
  .pi_o(pi_o), .cycle_cnt_o(cycle_cnt_o), .busy_o(busy_o), .done_o(done_o),
  .fail_o(fail_o), .fail_vec_o(fail_vec_o)
);

// File: tb/tb_scan_test_seq.sv
`timescale 1ns/1ps
module tb_scan_test_seq;
  localparam int NCH = 2, LEN = 4, NPI = 3, NPO = 2, VIDX_W = 4, CYC_W = 16;
  localparam int VB = NCH * LEN;

  localparam logic [VB+NPI-1:0] VEC_TAB [4] = '{
    {8'hA5, 3'b101}, {8'h3C, 3'b010}, {8'hF0, 3'b111}, {8'h96, 3'b000}
  };

  logic clk, rst_n, start_i, vec_valid_i, vec_ready_o, vec_last_i;
  logic [VB-1:0] vec_load_i, vec_so_exp_i, vec_so_care_i;
  logic [NPI-1:0] vec_pi_i, pi_o;
  logic [NPO-1:0] vec_po_exp_i, po_i;
  logic tclk_en_o, test_ctl_o, busy_o, done_o, fail_o;
  logic [NCH-1:0] scan_in_o, scan_out_i;
  logic [CYC_W-1:0] cycle_cnt_o;
  logic [VIDX_W-1:0] fail_vec_o;

  scan_test_seq #(.NCH(NCH), .CHAIN_LEN(LEN), .NPI(NPI), .NPO(NPO),
                  .VIDX_W(VIDX_W), .CYC_W(CYC_W)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scanned design model
  logic [LEN-1:0] chain [NCH];
  logic brk_so;
  function automatic logic [LEN-1:0] cap_fn(input int c, input logic [LEN-1:0] s, input logic [NPI-1:0] p);
    return {s[LEN-2:0], s[LEN-1]} ^ (LEN'(p) << c);
  endfunction
  always @(posedge clk)
    if (tclk_en_o)
      for (int c = 0; c < NCH; c++)
        chain[c] <= test_ctl_o ? cap_fn(c, chain[c], pi_o) : {chain[c][LEN-2:0], scan_in_o[c]};
  always_comb begin
    for (int c = 0; c < NCH; c++) scan_out_i[c] = chain[c][LEN-1] ^ (brk_so && c == 0);
    for (int k = 0; k < NPO; k++) po_i[k] = (^chain[k]) ^ pi_o[k];
  end

  // run description
  logic [VB-1:0] r_load [4], r_so_xor [4], r_care [4];
  logic [NPI-1:0] r_pi [4];
  logic [NPO-1:0] r_po_xor [4];

  // monitor
  int tcnt = 0, capidx = 0;
  always @(negedge clk) begin
    if (rst_n && start_i && !busy_o) begin tcnt = 0; capidx = 0; end
    if (rst_n && tclk_en_o) begin
      if (tcnt < LEN + 4)
        chk(!test_ctl_o && scan_in_o == {NCH{1'((tcnt >> 1) & 1)}}, "R2 flush pattern",
            {test_ctl_o, scan_in_o}, {1'b0, {NCH{1'((tcnt >> 1) & 1)}}});
      if (test_ctl_o) begin
        chk({chain[1], chain[0]} == r_load[capidx], "R4 chain after load",
            {chain[1], chain[0]}, r_load[capidx]);
        chk(pi_o == r_pi[capidx], "R1 pi at capture", pi_o, r_pi[capidx]);
        capidx++;
      end else if (pi_o != '0) chk(1'b0, "R1 pi outside capture", pi_o, 0);
      tcnt++;
    end
    if (vec_ready_o && tclk_en_o) chk(1'b0, "R9 clock while waiting", 1, 0);
  end

  task automatic load_table();
    for (int i = 0; i < 4; i++) begin
      r_load[i] = VEC_TAB[i][NPI +: VB];
      r_pi[i] = VEC_TAB[i][NPI-1:0];
      r_so_xor[i] = '0; r_care[i] = '1; r_po_xor[i] = '0;
    end
  endtask

  task automatic run_seq(input int nvec, input int stall, input bit poke);
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    for (int i = 0; i < nvec; i++) begin
      forever begin @(negedge clk); if (vec_ready_o) break; end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(!tclk_en_o, "R9 stall no clock", tclk_en_o, 0);
      end
      if (poke && i == 2) begin
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
      end
      @(posedge clk); #1;
      vec_valid_i = 1'b1;
      vec_last_i = (i == nvec - 1);
      vec_load_i = r_load[i];
      vec_pi_i = r_pi[i];
      vec_so_exp_i = {cap_fn(1, r_load[i][LEN +: LEN], r_pi[i]),
                      cap_fn(0, r_load[i][0 +: LEN], r_pi[i])} ^ r_so_xor[i];
      vec_so_care_i = r_care[i];
      for (int k = 0; k < NPO; k++)
        vec_po_exp_i[k] = (^r_load[i][k*LEN +: LEN]) ^ r_pi[i][k] ^ r_po_xor[i][k];
      forever begin @(negedge clk); if (vec_ready_o) break; end
      @(posedge clk); #1 vec_valid_i = 1'b0;
    end
    forever begin @(negedge clk); if (done_o) break; end
  endtask

  task automatic check_end(input int nvec, input string tag);
    int exp_cyc;
    exp_cyc = (nvec + 2) * LEN + nvec + 4;
    chk(cycle_cnt_o == CYC_W'(exp_cyc), {tag, " R9 cycle count"}, cycle_cnt_o, exp_cyc);
    chk(tcnt == exp_cyc && capidx == nvec, {tag, " R8 unload length"}, tcnt, exp_cyc);
    chk(!busy_o, {tag, " R8 idle at done"}, busy_o, 0);
    @(negedge clk);
    chk(!done_o && !busy_o, {tag, " R8 single done"}, done_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; vec_valid_i = 1'b0; vec_last_i = 1'b0; brk_so = 1'b0;
    vec_load_i = '0; vec_pi_i = '0; vec_po_exp_i = '0; vec_so_exp_i = '0; vec_so_care_i = '0;
    load_table();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, fail_o, tclk_en_o, test_ctl_o, vec_ready_o} == '0, "R10 reset outputs",
        {busy_o, done_o, fail_o, tclk_en_o, test_ctl_o, vec_ready_o}, 0);
    chk(cycle_cnt_o == '0, "R9 reset count", cycle_cnt_o, 0);

    // table walk, clean
    run_seq(4, 0, 0); check_end(4, "clean");
    chk(!fail_o, "R5 R7 clean run", fail_o, 0);
    // second run: stale previous expectations must not be compared
    run_seq(4, 0, 0); check_end(4, "rerun");
    chk(!fail_o, "R6 first load unchecked", fail_o, 0);
    // stalls
    run_seq(4, 3, 0); check_end(4, "stall");
    chk(!fail_o, "R9 stalled run clean", fail_o, 0);
    // start while busy
    run_seq(4, 0, 1); check_end(4, "poke");
    chk(!fail_o, "R11 start while busy", fail_o, 0);
    // single vector
    run_seq(1, 0, 0); check_end(1, "single");
    chk(!fail_o, "R9 single vector clean", fail_o, 0);
    // masked corruption
    r_so_xor[1] = 8'h04; r_care[1] = ~8'h04;
    run_seq(4, 0, 0); check_end(4, "masked");
    chk(!fail_o, "R5 masked bit ignored", fail_o, 0);
    // cared corruption in vectors 2 and 3
    load_table(); r_so_xor[2] = 8'h40; r_so_xor[3] = 8'h01;
    run_seq(4, 0, 0); check_end(4, "cared");
    chk(fail_o && fail_vec_o == 4'd2, "R5 R10 first failing index", {fail_o, fail_vec_o}, {1'b1, 4'd2});
    // clean run clears
    load_table();
    run_seq(4, 0, 0); check_end(4, "clear");
    chk(!fail_o && fail_vec_o == '0, "R10 cleared by start", {fail_o, fail_vec_o}, 0);
    // primary output mismatch
    r_po_xor[1] = 2'b01;
    run_seq(4, 0, 0); check_end(4, "po");
    chk(fail_o && fail_vec_o == 4'd1, "R7 po mismatch index", {fail_o, fail_vec_o}, {1'b1, 4'd1});
    // broken chain
    load_table(); brk_so = 1'b1;
    run_seq(2, 0, 0); check_end(2, "flush");
    chk(fail_o && fail_vec_o == 4'hF, "R3 flush failure", {fail_o, fail_vec_o}, {1'b1, 4'hF});
    brk_so = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule